// File: doc/BRIEF.md
# DSP Data Address Generator with Post-Modify

This block produces the memory addresses for a 16-bit signal processor. It holds four pointer registers and four step registers; the step register that goes with pointer n is step register n. A pointer load or pointer store issues its access at the pointer's current value. In the same clock edge the pointer is rewritten with one of four updates: keep it, subtract one, add one, or add its step register. All arithmetic wraps at 16 bits.

Other opcodes are also decoded. A short direct form turns a signed 8-bit field of the opcode into a data address. A code-memory indirect read fetches through a pointer and updates that pointer. A step-add instruction adds any step register to any pointer without a memory access. Each access also reports the general register number that takes or supplies the data. Software loads pointers and step registers through a single write port.

Top module: `dsp_addr_unit`

## Requirements
- R1: After synchronous reset every strobe output and `illegal_op` is low, `dmem_addr`, `imem_addr` and `gpr_sel` are zero, and all pointer and step registers read as zero.
- R2: A valid opcode whose bits 15:9 are 0001100 is a pointer load. One cycle later `dmem_rd` is high, `dmem_addr` holds the pointer selected by bits 6:5 as it was before the update, and `gpr_sel` equals bits 4:0.
- R3: For pointer loads and stores the update code is {bit 8, bit 7}. 00 keeps the pointer, 01 subtracts one, 10 adds one, and 11 adds the step register with the same number. Every result wraps modulo 2^16.
- R4: A valid opcode whose bits 15:9 are 0001101 is a pointer store. It is decoded like R2 and R3, but it raises `dmem_wr` instead of `dmem_rd`, and `gpr_sel` names the source register.
- R5: A valid opcode whose bits 15:11 are 00100 (load) or 00101 (store) is a short direct access. The address is bits 7:0 sign-extended to 16 bits, `gpr_sel` is 0x18 plus bits 10:8, and no pointer changes.
- R6: The opcode form 0000 001a 0001 mmpp is a code-memory read. One cycle later `imem_rd` is high, `imem_addr` holds pointer pp before its update, and `gpr_sel` is 0x1E+a. For mm, 0 keeps the pointer, 1 subtracts one and 2 adds one.
- R7: When mm is 3 in the R6 form, the read is still performed and the pointer is left unchanged. `illegal_op` is high for the one cycle in which that read is presented.
- R8: The opcode 0000 0000 0001 ssdd adds step register ss to pointer dd (modulo 2^16). It raises no strobe.
- R9: `rf_we` with `rf_sel` 0..3 writes pointer `rf_sel`, and with 4..7 it writes step register `rf_sel`-4. The new value is in use from the next cycle. If a post-modify targets the same pointer in the same cycle, the write wins.
- R10: When `op_valid` is low, or the opcode matches none of the forms above, no strobe rises and no register changes.
- R11: Operations issued on consecutive cycles see each other's updates, so back-to-back post-increment loads produce consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode present this cycle |
| opcode | input | 16 | Instruction word |
| rf_we | input | 1 | Pointer/step register write enable |
| rf_sel | input | 3 | Write target: 0-3 pointers, 4-7 step registers |
| rf_wdata | input | 16 | Write data |
| dmem_addr | output | 16 | Data memory address (zero when idle) |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| imem_addr | output | 16 | Code memory read address (zero when idle) |
| imem_rd | output | 1 | Code memory read strobe |
| gpr_sel | output | 5 | General register that sinks or sources the data |
| illegal_op | output | 1 | Reserved code-memory read mode seen |

## Verification
Each access result (strobes, addresses, `gpr_sel`, `illegal_op`) is registered once, so it is due exactly one clock after the opcode is presented. A pointer or step register write, and a post-modify, appear in the address of the next operation. The bench drives on the falling edge and samples outputs on the following falling edge, after one rising edge has passed. It reads a pointer's value by issuing a keep-mode load and checking the address that load presents. Back-to-back cases issue without an idle cycle, to confirm that the update is visible one cycle after it is made.

// File: rtl/dau_pkg.sv
package dau_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_PTR   = 4;
    localparam int PTR_IDX_W = $clog2(NUM_PTR);
    localparam int REG_ID_W  = 5;

    typedef enum logic [1:0] {
        PM_HOLD  = 2'd0,
        PM_DEC   = 2'd1,
        PM_INC   = 2'd2,
        PM_INDEX = 2'd3
    } post_mod_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_PLOAD,
        K_PSTORE,
        K_SLOAD,
        K_SSTORE,
        K_IREAD,
        K_ADDIX
    } op_kind_e;

    typedef struct packed {
        op_kind_e               kind;
        logic [PTR_IDX_W-1:0]   ptr;
        logic [PTR_IDX_W-1:0]   idx;
        post_mod_e              mode;
        logic [REG_ID_W-1:0]    gpr;
        logic [WORD_W-1:0]      direct;
        logic                   reserved;
    } dec_t;

    function automatic dec_t decode_op(input logic [WORD_W-1:0] op);
        dec_t d;
        d.kind     = K_NONE;
        d.ptr      = op[6:5];
        d.idx      = op[6:5];
        d.mode     = post_mod_e'({op[8], op[7]});
        d.gpr      = op[4:0];
        d.direct   = {{(WORD_W-8){op[7]}}, op[7:0]};
        d.reserved = 1'b0;
        if (op[15:9] == 7'b0001100) begin
            d.kind = K_PLOAD;
        end else if (op[15:9] == 7'b0001101) begin
            d.kind = K_PSTORE;
        end else if (op[15:11] == 5'b00100 || op[15:11] == 5'b00101) begin
            d.kind = op[11] ? K_SSTORE : K_SLOAD;
            d.gpr  = {2'b11, op[10:8]};
            d.mode = PM_HOLD;
        end else if (op[15:9] == 7'b0000001 && op[7:4] == 4'b0001) begin
            d.kind     = K_IREAD;
            d.ptr      = op[1:0];
            d.idx      = op[1:0];
            d.gpr      = {4'b1111, op[8]};
            d.reserved = (op[3:2] == 2'd3);
            d.mode     = d.reserved ? PM_HOLD : post_mod_e'(op[3:2]);
        end else if (op[15:4] == 12'h001) begin
            d.kind = K_ADDIX;
            d.ptr  = op[1:0];
            d.idx  = op[3:2];
            d.mode = PM_INDEX;
        end
        return d;
    endfunction

endpackage

// File: rtl/dau_decode.sv
module dau_decode
    import dau_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] op,
    output dec_t              dec
);
    always_comb begin
        dec = decode_op(op);
        if (!valid) dec.kind = K_NONE;
    end
endmodule

// File: rtl/dau_modify.sv
module dau_modify
    import dau_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] step,
    input  post_mod_e    mode,
    output logic [W-1:0] result
);
    always_comb begin
        unique case (mode)
            PM_DEC:   result = base - W'(1);
            PM_INC:   result = base + W'(1);
            PM_INDEX: result = base + step;
            default:  result = base;
        endcase
    end
endmodule

// File: rtl/dau_regs.sv
module dau_regs #(
    parameter int W = 16,
    parameter int N = 4,
    localparam int PW = $clog2(N),
    localparam int SW = PW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic                upd_en,
    input  logic [PW-1:0]       upd_ptr,
    input  logic [W-1:0]        upd_val,
    output logic [N-1:0][W-1:0] ptr_q,
    output logic [N-1:0][W-1:0] step_q
);
    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[i] <= '0;
            end else if (wr_en && wr_sel == SW'(i)) begin
                ptr_q[i] <= wr_data;
            end else if (upd_en && upd_ptr == PW'(i)) begin
                ptr_q[i] <= upd_val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                step_q[i] <= '0;
            end else if (wr_en && wr_sel == SW'(N + i)) begin
                step_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dsp_addr_unit.sv
module dsp_addr_unit
    import dau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [15:0] opcode,
    input  logic        rf_we,
    input  logic [2:0]  rf_sel,
    input  logic [15:0] rf_wdata,
    output logic [15:0] dmem_addr,
    output logic        dmem_rd,
    output logic        dmem_wr,
    output logic [15:0] imem_addr,
    output logic        imem_rd,
    output logic [4:0]  gpr_sel,
    output logic        illegal_op
);
    dec_t                          dec;
    logic [NUM_PTR-1:0][WORD_W-1:0] ptr_q;
    logic [NUM_PTR-1:0][WORD_W-1:0] step_q;
    logic [WORD_W-1:0]             cur_ptr;
    logic [WORD_W-1:0]             cur_step;
    logic [WORD_W-1:0]             new_ptr;
    logic                          upd_en;

    dau_decode u_dec (
        .valid (op_valid),
        .op    (opcode),
        .dec   (dec)
    );

    assign cur_ptr  = ptr_q[dec.ptr];
    assign cur_step = step_q[dec.idx];
    assign upd_en   = (dec.kind == K_PLOAD) || (dec.kind == K_PSTORE) ||
                      (dec.kind == K_IREAD) || (dec.kind == K_ADDIX);

    dau_modify #(.W(WORD_W)) u_mod (
        .base   (cur_ptr),
        .step   (cur_step),
        .mode   (dec.mode),
        .result (new_ptr)
    );

    dau_regs #(.W(WORD_W), .N(NUM_PTR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_we),
        .wr_sel  (rf_sel),
        .wr_data (rf_wdata),
        .upd_en  (upd_en),
        .upd_ptr (dec.ptr),
        .upd_val (new_ptr),
        .ptr_q   (ptr_q),
        .step_q  (step_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dmem_addr  <= '0;
            dmem_rd    <= 1'b0;
            dmem_wr    <= 1'b0;
            imem_addr  <= '0;
            imem_rd    <= 1'b0;
            gpr_sel    <= '0;
            illegal_op <= 1'b0;
        end else begin
            dmem_addr  <= '0;
            dmem_rd    <= 1'b0;
            dmem_wr    <= 1'b0;
            imem_addr  <= '0;
            imem_rd    <= 1'b0;
            gpr_sel    <= '0;
            illegal_op <= 1'b0;
            unique case (dec.kind)
                K_PLOAD: begin
                    dmem_addr <= cur_ptr;
                    dmem_rd   <= 1'b1;
                    gpr_sel   <= dec.gpr;
                end
                K_PSTORE: begin
                    dmem_addr <= cur_ptr;
                    dmem_wr   <= 1'b1;
                    gpr_sel   <= dec.gpr;
                end
                K_SLOAD: begin
                    dmem_addr <= dec.direct;
                    dmem_rd   <= 1'b1;
                    gpr_sel   <= dec.gpr;
                end
                K_SSTORE: begin
                    dmem_addr <= dec.direct;
                    dmem_wr   <= 1'b1;
                    gpr_sel   <= dec.gpr;
                end
                K_IREAD: begin
                    imem_addr  <= cur_ptr;
                    imem_rd    <= 1'b1;
                    gpr_sel    <= dec.gpr;
                    illegal_op <= dec.reserved;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dau_checker.sv
module dau_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [15:0] opcode,
    input logic [15:0] dmem_addr,
    input logic        dmem_rd,
    input logic        dmem_wr,
    input logic        imem_rd,
    input logic [4:0]  gpr_sel,
    input logic        illegal_op
);
    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dmem_rd, dmem_wr, imem_rd}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !dmem_rd && !dmem_wr && !imem_rd && !illegal_op);

    // R7
    illegal_with_read_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> imem_rd);

    // R5
    short_load_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode[15:11] == 5'b00100 |=>
            dmem_rd && dmem_addr == {{8{$past(opcode[7])}}, $past(opcode[7:0])} &&
            gpr_sel == {2'b11, $past(opcode[10:8])});

    // R5
    short_store_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode[15:11] == 5'b00101 |=> dmem_wr && !dmem_rd);

    // R2
    ptr_load_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && opcode[15:9] == 7'b0001100 |=> dmem_rd);
endmodule

bind dsp_addr_unit dau_checker u_dau_checker (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .dmem_addr  (dmem_addr),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .imem_rd    (imem_rd),
    .gpr_sel    (gpr_sel),
    .illegal_op (illegal_op)
);

// File: tb/tb_dsp_addr_unit.sv
module tb_dsp_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_sel = '0;
    logic [15:0] rf_wdata = '0;
    logic [15:0] dmem_addr, imem_addr;
    logic        dmem_rd, dmem_wr, imem_rd, illegal_op;
    logic [4:0]  gpr_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dsp_addr_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .gpr_sel(gpr_sel),
        .illegal_op(illegal_op)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return idle at the next falling edge.
    task automatic apply(input logic v, input logic [15:0] op,
                         input logic we, input logic [2:0] sel, input logic [15:0] d);
        op_valid = v; opcode = op; rf_we = we; rf_sel = sel; rf_wdata = d;
        @(negedge clk);
        op_valid = 1'b0; opcode = '0; rf_we = 1'b0; rf_sel = '0; rf_wdata = '0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        apply(1'b0, 16'h0000, 1'b1, sel, d);
    endtask

    task automatic peek(input string req, input logic [1:0] p, input logic [15:0] exp);
        apply(1'b1, 16'h1800 | (16'(p) << 5), 1'b0, 3'd0, 16'h0);
        chk(req, "pointer value", dmem_addr, exp);
    endtask

    task automatic strobes(input string req, input logic r, input logic w, input logic i);
        chk(req, "strobes rd/wr/imem", {13'd0, dmem_rd, dmem_wr, imem_rd}, {13'd0, r, w, i});
    endtask

    task automatic t_reset;
        strobes("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "dmem_addr", dmem_addr, 16'h0);
        chk("R1", "imem_addr", imem_addr, 16'h0);
        chk("R1", "gpr_sel", {11'd0, gpr_sel}, 16'h0);
        chk("R1", "illegal_op", {15'd0, illegal_op}, 16'h0);
        for (int p = 0; p < 4; p++) peek("R1", 2'(p), 16'h0000);
    endtask

    task automatic t_load_modes;
        wr(3'd1, 16'h1000);
        wr(3'd5, 16'h0020);
        peek("R9", 2'd1, 16'h1000);
        apply(1'b1, 16'h1825, 1'b0, 3'd0, 16'h0);
        strobes("R2", 1'b1, 1'b0, 1'b0);
        chk("R2", "load addr", dmem_addr, 16'h1000);
        chk("R2", "load dest", {11'd0, gpr_sel}, 16'h0005);
        peek("R3", 2'd1, 16'h1000);
        apply(1'b1, 16'h18A5, 1'b0, 3'd0, 16'h0);
        chk("R3", "dec addr", dmem_addr, 16'h1000);
        peek("R3", 2'd1, 16'h0FFF);
        apply(1'b1, 16'h1925, 1'b0, 3'd0, 16'h0);
        chk("R3", "inc addr", dmem_addr, 16'h0FFF);
        peek("R3", 2'd1, 16'h1000);
        apply(1'b1, 16'h19A5, 1'b0, 3'd0, 16'h0);
        chk("R3", "index addr", dmem_addr, 16'h1000);
        peek("R3", 2'd1, 16'h1020);
    endtask

    task automatic t_wrap;
        wr(3'd2, 16'h0000);
        apply(1'b1, 16'h18C0, 1'b0, 3'd0, 16'h0);
        chk("R3", "dec from zero addr", dmem_addr, 16'h0000);
        peek("R3", 2'd2, 16'hFFFF);
        apply(1'b1, 16'h1940, 1'b0, 3'd0, 16'h0);
        peek("R3", 2'd2, 16'h0000);
        wr(3'd2, 16'h0008);
        wr(3'd6, 16'hFFF0);
        apply(1'b1, 16'h19C0, 1'b0, 3'd0, 16'h0);
        peek("R3", 2'd2, 16'hFFF8);
    endtask

    task automatic t_store;
        wr(3'd3, 16'h0200);
        wr(3'd7, 16'h0004);
        apply(1'b1, 16'h1B7F, 1'b0, 3'd0, 16'h0);
        strobes("R4", 1'b0, 1'b1, 1'b0);
        chk("R4", "store addr", dmem_addr, 16'h0200);
        chk("R4", "store source", {11'd0, gpr_sel}, 16'h001F);
        peek("R4", 2'd3, 16'h0201);
        apply(1'b1, 16'h1BE0, 1'b0, 3'd0, 16'h0);
        chk("R4", "store index addr", dmem_addr, 16'h0201);
        peek("R4", 2'd3, 16'h0205);
        apply(1'b1, 16'h1AE0, 1'b0, 3'd0, 16'h0);
        chk("R4", "store dec addr", dmem_addr, 16'h0205);
        peek("R4", 2'd3, 16'h0204);
    endtask

    task automatic t_short;
        apply(1'b1, 16'h2380, 1'b0, 3'd0, 16'h0);
        strobes("R5", 1'b1, 1'b0, 1'b0);
        chk("R5", "short load addr", dmem_addr, 16'hFF80);
        chk("R5", "short load dest", {11'd0, gpr_sel}, 16'h001B);
        apply(1'b1, 16'h2C05, 1'b0, 3'd0, 16'h0);
        strobes("R5", 1'b0, 1'b1, 1'b0);
        chk("R5", "short store addr", dmem_addr, 16'h0005);
        chk("R5", "short store src", {11'd0, gpr_sel}, 16'h001C);
        peek("R5", 2'd3, 16'h0204);
    endtask

    task automatic t_imem;
        wr(3'd0, 16'h0040);
        apply(1'b1, 16'h0318, 1'b0, 3'd0, 16'h0);
        strobes("R6", 1'b0, 1'b0, 1'b1);
        chk("R6", "imem addr", imem_addr, 16'h0040);
        chk("R6", "imem dest", {11'd0, gpr_sel}, 16'h001F);
        peek("R6", 2'd0, 16'h0041);
        apply(1'b1, 16'h0214, 1'b0, 3'd0, 16'h0);
        chk("R6", "imem dec addr", imem_addr, 16'h0041);
        chk("R6", "imem dest a0", {11'd0, gpr_sel}, 16'h001E);
        peek("R6", 2'd0, 16'h0040);
        apply(1'b1, 16'h0210, 1'b0, 3'd0, 16'h0);
        chk("R6", "imem hold addr", imem_addr, 16'h0040);
        peek("R6", 2'd0, 16'h0040);
    endtask

    task automatic t_reserved;
        apply(1'b1, 16'h021C, 1'b0, 3'd0, 16'h0);
        strobes("R7", 1'b0, 1'b0, 1'b1);
        chk("R7", "reserved addr", imem_addr, 16'h0040);
        chk("R7", "illegal_op", {15'd0, illegal_op}, 16'h0001);
        apply(1'b0, 16'h0000, 1'b0, 3'd0, 16'h0);
        chk("R7", "illegal_op drops", {15'd0, illegal_op}, 16'h0000);
        peek("R7", 2'd0, 16'h0040);
    endtask

    task automatic t_addix;
        wr(3'd2, 16'h0100);
        apply(1'b1, 16'h0016, 1'b0, 3'd0, 16'h0);
        strobes("R8", 1'b0, 1'b0, 1'b0);
        peek("R8", 2'd2, 16'h0120);
        wr(3'd4, 16'hFFFE);
        apply(1'b1, 16'h0012, 1'b0, 3'd0, 16'h0);
        peek("R8", 2'd2, 16'h011E);
    endtask

    task automatic t_back_to_back;
        wr(3'd1, 16'h3000);
        apply(1'b1, 16'h1925, 1'b0, 3'd0, 16'h0);
        chk("R11", "first addr", dmem_addr, 16'h3000);
        apply(1'b1, 16'h1925, 1'b0, 3'd0, 16'h0);
        chk("R11", "second addr", dmem_addr, 16'h3001);
        peek("R11", 2'd1, 16'h3002);
    endtask

    task automatic t_collide;
        apply(1'b1, 16'h1900, 1'b1, 3'd0, 16'h7777);
        chk("R9", "access uses old ptr", dmem_addr, 16'h0040);
        peek("R9", 2'd0, 16'h7777);
    endtask

    task automatic t_ignore;
        apply(1'b0, 16'h1900, 1'b0, 3'd0, 16'h0);
        strobes("R10", 1'b0, 1'b0, 1'b0);
        apply(1'b1, 16'hFFFF, 1'b0, 3'd0, 16'h0);
        strobes("R10", 1'b0, 1'b0, 1'b0);
        apply(1'b1, 16'h0000, 1'b0, 3'd0, 16'h0);
        strobes("R10", 1'b0, 1'b0, 1'b0);
        peek("R10", 2'd0, 16'h7777);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_modes();
        t_wrap();
        t_store();
        t_short();
        t_imem();
        t_reserved();
        t_addix();
        t_back_to_back();
        t_collide();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule